// File: doc/BRIEF.md
# Set/Clear GPIO Port with Implicit Direction

This block is a 32-pin general-purpose I/O port sitting on a simple memory-mapped register bus. No register holds the pin direction directly. A write to the output-set or output-clear register drives the addressed pins high or low and also makes them outputs. A write to the tristate-clear register turns the addressed pins back into inputs. Only bits written as 1 act; bits written as 0 leave their pins as they were.

Several offsets do one thing on a read and another on a write. The tristate-clear offset reads back the output-enable vector. The set offset reads back the output data. The pin-state offset returns the live pins, after a two-flop synchronizer. Any write to the pin-state offset permanently arms input sampling. Until that first write, the synchronizer stays cleared and pin-state reads return zero.

The bus is a plain single-cycle strobe interface with no handshake. A write takes effect at the clock edge that samples `bus_wr`. A read loads `bus_rdata` at the clock edge that samples `bus_rd`.

Top module: `sc_gpio_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), `pin_out` is 0, and input sampling is disarmed.
- R2: A write to offset 0x108 sets `pin_out` and `pin_oe` for every pin whose data bit is 1, at the edge that samples `bus_wr`. Pins whose data bit is 0 keep both values.
- R3: A write to offset 0x10C clears `pin_out` and sets `pin_oe` for every pin whose data bit is 1. Pins whose data bit is 0 keep both values.
- R4: A write to offset 0x100 clears `pin_oe` for every pin whose data bit is 1 and leaves `pin_out` unchanged. Pins whose data bit is 0 keep both values.
- R5: A read of offset 0x100 returns `pin_oe`, a read of 0x108 returns the output data, and a read of 0x10C returns 0.
- R6: While sampling is disarmed, a read of offset 0x110 returns 0 whatever `pin_in` carries.
- R7: Any write to offset 0x110, including data 0, arms sampling. Sampling stays armed through later writes of any value until reset. Such a write changes neither `pin_out` nor `pin_oe`.
- R8: Once armed, a read of 0x110 returns `pin_in` through two flops. A value first sampled from `pin_in` at edge k is returned by a read sampled at edge k+2 or later. A read sampled at edge k+1 still returns the previous value.
- R9: Writes to any other offset change neither `pin_out`, `pin_oe` nor the armed state, and reads from such offsets return 0.
- R10: `bus_rdata` is loaded only at an edge that samples `bus_rd` = 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Raw pin levels from the pads |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |

## Verification
The bench writes masks that mix ones and zeros. A design that touched unaddressed pins, or that wrote the direction without the data, would show a wrong `pin_out` or `pin_oe` vector. It checks that tristate-clear keeps the output level, so a design that cleared the data as well would be caught when the pin is re-enabled. Before arming, it drives pins high and expects zero from the pin-state read. It arms with a zero data word and writes zero again afterwards, which catches a design that decodes the data value or lets a later write disarm. It reads one cycle and two cycles after a pin change, which catches a synchronizer with the wrong depth. Reads and writes at offset 0x10C and at unmapped offsets show any decode that aliases addresses.

// File: rtl/sc_gpio_pkg.sv
package sc_gpio_pkg;
  localparam logic [11:0] OFS_OE_CLR  = 12'h100;
  localparam logic [11:0] OFS_OUT_SET = 12'h108;
  localparam logic [11:0] OFS_OUT_CLR = 12'h10C;
  localparam logic [11:0] OFS_PIN     = 12'h110;

  typedef struct packed {
    logic oe_clr;
    logic out_set;
    logic out_clr;
    logic in_arm;
  } wr_strobe_t;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_OE   = 2'd1,
    RSEL_OUT  = 2'd2,
    RSEL_PIN  = 2'd3
  } rsel_e;
endpackage

// File: rtl/sc_gpio_decode.sv
module sc_gpio_decode
  import sc_gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output wr_strobe_t        stb,
  output rsel_e             rsel
);
  logic hit_oe, hit_set, hit_clr, hit_pin;

  always_comb begin
    hit_oe  = (addr == ADDR_W'(OFS_OE_CLR));
    hit_set = (addr == ADDR_W'(OFS_OUT_SET));
    hit_clr = (addr == ADDR_W'(OFS_OUT_CLR));
    hit_pin = (addr == ADDR_W'(OFS_PIN));

    stb.oe_clr  = wr & hit_oe;
    stb.out_set = wr & hit_set;
    stb.out_clr = wr & hit_clr;
    stb.in_arm  = wr & hit_pin;

    // the clear offset is write-only and reads as an unmapped offset
    if (hit_oe)        rsel = RSEL_OE;
    else if (hit_set)  rsel = RSEL_OUT;
    else if (hit_pin)  rsel = RSEL_PIN;
    else               rsel = RSEL_NONE;
  end
endmodule

// File: rtl/sc_gpio_drive.sv
module sc_gpio_drive
  import sc_gpio_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  wr_strobe_t      stb,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] oe_q
);
  logic [PINS-1:0] out_d, oe_d;

  always_comb begin
    out_d = out_q;
    oe_d  = oe_q;
    for (int i = 0; i < PINS; i++) begin
      if (wdata[i]) begin
        if (stb.out_set) begin
          out_d[i] = 1'b1;
          oe_d[i]  = 1'b1;
        end else if (stb.out_clr) begin
          out_d[i] = 1'b0;
          oe_d[i]  = 1'b1;
        end else if (stb.oe_clr) begin
          oe_d[i]  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  // R2
  set_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.out_set |=> (((out_q & oe_q) & $past(wdata)) == $past(wdata)));
  // R3
  clr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.out_clr |=> (((~out_q & oe_q) & $past(wdata)) == $past(wdata)));
  // R4
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.oe_clr |=> (((oe_q & $past(wdata)) == '0) && $stable(out_q)));
  // R2
  untouched_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.out_set || stb.out_clr || stb.oe_clr) |=>
      (((out_q ^ $past(out_q)) | (oe_q ^ $past(oe_q))) & ~$past(wdata)) == '0);
  // R7
  arm_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.in_arm && !stb.out_set && !stb.out_clr && !stb.oe_clr) |=>
      ($stable(out_q) && $stable(oe_q)));
endmodule

// File: rtl/sc_gpio_sample.sv
module sc_gpio_sample #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [PINS-1:0] pin_in,
  output logic            armed,
  output logic [PINS-1:0] state
);
  logic [STAGES-1:0][PINS-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (arm)    armed <= 1'b1;
  end

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain <= '0;
        else if (!armed) chain <= '0;
        else             chain[0] <= pin_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain <= '0;
        else if (!armed) chain <= '0;
        else             chain <= {chain[STAGES-2:0], pin_in};
      end
    end
  endgenerate

  assign state = chain[STAGES-1];

  // R7
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  // R6
  dead_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (state == '0));
endmodule

// File: rtl/sc_gpio_port.sv
module sc_gpio_port
  import sc_gpio_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_rd,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  localparam int unsigned SYNC_STAGES = 2;

  wr_strobe_t      stb;
  rsel_e           rsel;
  logic            armed;
  logic [PINS-1:0] pin_state;
  logic [PINS-1:0] rd_mux;

  sc_gpio_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .wr   (bus_wr),
    .stb  (stb),
    .rsel (rsel)
  );

  sc_gpio_drive #(.PINS(PINS)) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (stb),
    .wdata (bus_wdata),
    .out_q (pin_out),
    .oe_q  (pin_oe)
  );

  sc_gpio_sample #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sample (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (stb.in_arm),
    .pin_in (pin_in),
    .armed  (armed),
    .state  (pin_state)
  );

  always_comb begin
    unique case (rsel)
      RSEL_OE:  rd_mux = pin_oe;
      RSEL_OUT: rd_mux = pin_out;
      RSEL_PIN: rd_mux = pin_state;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rsel == RSEL_NONE) |=> (bus_rdata == '0));
  // R5
  oe_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rsel == RSEL_OE) |=> (bus_rdata == $past(pin_oe)));
  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && rsel == RSEL_NONE && bus_addr != ADDR_W'(OFS_OUT_CLR)) |=>
      ($stable(pin_out) && $stable(pin_oe) && $stable(armed)));
endmodule

// File: tb/sc_gpio_port_tb.sv
module sc_gpio_port_tb;
  localparam int unsigned PINS = 32;
  localparam int unsigned AW   = 12;
  localparam logic [AW-1:0] A_OE  = 12'h100;
  localparam logic [AW-1:0] A_SET = 12'h108;
  localparam logic [AW-1:0] A_CLR = 12'h10C;
  localparam logic [AW-1:0] A_PIN = 12'h110;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [PINS-1:0] bus_wdata = '0;
  logic            bus_rd = 1'b0;
  logic [PINS-1:0] bus_rdata;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_out;
  logic [PINS-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  logic [PINS-1:0] m_out, m_oe;
  bit done = 0;

  always #2 clk = ~clk;

  sc_gpio_port #(.PINS(PINS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [PINS-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_pins(input string req);
    check({req, " pin_out"}, pin_out, m_out);
    check({req, " pin_oe"}, pin_oe, m_oe);
  endtask

  task automatic t_reset();
    logic [PINS-1:0] r;
    pin_in = 32'hFFFF_FFFF;
    check_pins("R1");
    bus_read(A_PIN, r);
    check("R1 disarmed pin read", r, '0);
  endtask

  task automatic t_set();
    bus_write(A_SET, 32'h0000_00F5);
    m_out |= 32'h0000_00F5; m_oe |= 32'h0000_00F5;
    check_pins("R2 first set");
    bus_write(A_SET, 32'hA000_0100);
    m_out |= 32'hA000_0100; m_oe |= 32'hA000_0100;
    check_pins("R2 second set");
  endtask

  task automatic t_clear();
    bus_write(A_CLR, 32'h0000_0030);
    m_out &= ~32'h0000_0030; m_oe |= 32'h0000_0030;
    check_pins("R3 clear driven");
    bus_write(A_CLR, 32'h0C00_0000);
    m_oe |= 32'h0C00_0000;
    check_pins("R3 clear makes output low");
  endtask

  task automatic t_tristate();
    bus_write(A_OE, 32'h2000_0081);
    m_oe &= ~32'h2000_0081;
    check_pins("R4 release");
    bus_write(A_CLR, 32'h0000_0000);
    check_pins("R4 zero clear word");
  endtask

  task automatic t_readback();
    logic [PINS-1:0] r;
    bus_read(A_OE, r);
    check("R5 oe readback", r, m_oe);
    bus_read(A_SET, r);
    check("R5 data readback", r, m_out);
    bus_read(A_CLR, r);
    check("R5 clear offset reads 0", r, '0);
  endtask

  task automatic t_unmapped();
    logic [PINS-1:0] r;
    bus_write(12'h104, 32'hFFFF_FFFF);
    bus_write(12'h000, 32'hFFFF_FFFF);
    check_pins("R9 ignored writes");
    bus_read(12'h104, r);
    check("R9 unmapped read", r, '0);
    bus_read(12'h118, r);
    check("R9 unmapped read high", r, '0);
    bus_read(A_PIN, r);
    check("R9 unmapped write did not arm", r, '0);
  endtask

  task automatic t_hold();
    logic [PINS-1:0] r;
    bus_read(A_SET, r);
    repeat (3) @(negedge clk);
    bus_write(A_SET, 32'h0000_0002);
    m_out |= 32'h0000_0002; m_oe |= 32'h0000_0002;
    check("R10 rdata held", bus_rdata, r);
  endtask

  task automatic t_arm();
    logic [PINS-1:0] r;
    pin_in = 32'h5A5A_1234;
    bus_write(A_PIN, 32'h0000_0000);
    check_pins("R7 arm leaves pins");
    repeat (3) @(negedge clk);
    bus_read(A_PIN, r);
    check("R7 armed by zero write", r, 32'h5A5A_1234);
    bus_write(A_PIN, 32'h0000_0000);
    bus_write(A_PIN, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    bus_read(A_PIN, r);
    check("R7 stays armed", r, 32'h5A5A_1234);
  endtask

  task automatic t_sync();
    logic [PINS-1:0] r;
    @(negedge clk);
    pin_in = 32'hC3C3_0F0F;
    bus_read(A_PIN, r);
    check("R8 one edge old", r, 32'h5A5A_1234);
    bus_read(A_PIN, r);
    check("R8 two edges new", r, 32'hC3C3_0F0F);
  endtask

  task automatic t_rearm_reset();
    logic [PINS-1:0] r;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_out = '0; m_oe = '0;
    check_pins("R1 second reset");
    repeat (3) @(negedge clk);
    bus_read(A_PIN, r);
    check("R1 reset disarms", r, '0);
  endtask

  initial begin
    m_out = '0; m_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set();
    t_clear();
    t_tristate();
    t_readback();
    t_unmapped();
    t_hold();
    t_readback();
    t_arm();
    t_sync();
    t_rearm_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule